// File: doc/BRIEF.md
# First-Error Capture Status Register

This block watches three error strobes from a memory subsystem: an access to an address that nothing decodes, a parity fault in the tag control array of the board cache, and a parity fault in the tag address array. When the first of these arrives, it records which error it was. It also records which requester caused it (DMA or CPU), whether the access was a victim write-back, a 3-bit request code and the faulting address. It then holds that context frozen until software clears the error bits.

Any error that arrives while the context is frozen does not disturb the recorded information. It only raises a lost-error flag, so software knows that more than one fault happened. Software reads the status word at any time and clears the error bits by writing ones to them. The cause fields are read-only. They keep their last captured value until the next first error replaces them.

Top module: `err_capture_reg`

## Requirements
- R1: After reset the status word and the captured address are both zero.
- R2: The status word `stat_rd` packs its fields with the following bit positions. Bit 0 is the lost flag. Bit 1 is the tag-address parity error and bit 2 is the tag-control parity error. Bit 3 is the nonexistent-address error. Bit 4 is the DMA flag, bit 5 is the victim flag, and bits 8:6 hold the 3-bit cause code.
- R3: The capture is unlocked when bits 3:1 are all zero. In that state, any asserted error strobe sets its bit on the next cycle. If several strobes assert in the same cycle, all of their bits are set together and the context is captured once.
- R4: On a capture, the cause code takes `io_cmd` when `req_is_dma` is 1 and takes `cpu_req` when it is 0.
- R5: On a capture, the DMA flag takes `req_is_dma`. The victim flag takes `req_victim` when the nonexistent-address strobe is among the captured errors, and 0 otherwise.
- R6: On a capture, `err_addr` takes `req_addr`. While the capture is locked, `err_addr` holds its value.
- R7: An error strobe that arrives while the capture is locked sets bit 0. It leaves bits 8:4 and `err_addr` unchanged and sets none of bits 3:1.
- R8: A write with `wr_en` clears every bit among bits 3:0 whose `wr_data` bit is 1. Bits 8:4 ignore writes.
- R9: The lock is released once bits 3:1 are all cleared. An error strobe in the cycle after that clear captures fresh context.
- R10: If a write clears a bit in the same cycle that an error event sets that same bit, the bit remains 1.
- R11: Errors that arrive together while the capture is unlocked do not set bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_nxm | input | 1 | Strobe: access to an address that nothing decodes |
| err_tag_ctl | input | 1 | Strobe: tag control parity fault |
| err_tag_adr | input | 1 | Strobe: tag address parity fault |
| req_is_dma | input | 1 | Faulting request came from DMA (1) or the CPU (0) |
| req_victim | input | 1 | Faulting access was a victim write-back |
| cpu_req | input | 3 | CPU request code of the faulting access |
| io_cmd | input | 3 | I/O command code of the faulting access |
| req_addr | input | ADDR_W | Faulting address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Write data; ones clear bits 3:0 |
| stat_rd | output | 9 | Status word |
| err_addr | output | ADDR_W | Captured error address |

## Verification
The bench targets several corner cases, and each has a visible failure if the design gets it wrong:
- An error while locked: a design that recaptures here would overwrite the address and cause of the first fault.
- Simultaneous strobes while unlocked: a design that treats the second strobe as a later error would raise the lost flag wrongly.
- A clear in the same cycle as a set: a design where the clear wins would drop an error.
- The cycle right after the final clear: a design that releases the lock late would miss a new first error and count it as lost.
- The cause multiplexer: tests use distinct CPU and I/O codes, so selecting the wrong source shows up as a wrong cause code.
- The victim flag on parity-only faults, which must read 0.

Random traffic with dense writes and strobes also runs the lock and clear ordering against a bench model.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int CODE_W  = 3;
    localparam int NUM_ERR = 3;            // strobes that can lock the capture
    localparam int NUM_W1C = NUM_ERR + 1;  // error bits plus the lost flag
    localparam int STAT_W  = CODE_W + 2 + NUM_W1C;

    // Packed MSB first: cause[8:6], victim[5], dma[4], nxm[3],
    // tag_ctl[2], tag_adr[1], lost[0]
    typedef struct packed {
        logic [CODE_W-1:0] cause;
        logic              victim;
        logic              dma;
        logic              nxm;
        logic              tag_ctl;
        logic              tag_adr;
        logic              lost;
    } stat_t;

endpackage

// File: rtl/errcap_cause_sel.sv
module errcap_cause_sel
    import errcap_pkg::*;
(
    input  logic              is_dma,
    input  logic [CODE_W-1:0] cpu_code,
    input  logic [CODE_W-1:0] io_code,
    output logic [CODE_W-1:0] cause
);
    always_comb begin
        cause = is_dma ? io_code : cpu_code;
    end
endmodule

// File: rtl/errcap_event.sv
module errcap_event
    import errcap_pkg::*;
(
    input  logic [NUM_ERR-1:0] err_vec,
    input  logic               locked,
    output logic               capture,
    output logic               lost_evt
);
    logic any_err;

    always_comb begin
        any_err  = |err_vec;
        capture  = any_err && !locked;
        lost_evt = any_err && locked;
    end
endmodule

// File: rtl/errcap_w1c_bit.sv
module errcap_w1c_bit (
    input  logic cur,
    input  logic set,
    input  logic clr,
    output logic nxt
);
    // A set in the same cycle as a clear wins.
    always_comb begin
        nxt = set | (cur & ~clr);
    end
endmodule

// File: rtl/err_capture_reg.sv
module err_capture_reg
    import errcap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_nxm,
    input  logic              err_tag_ctl,
    input  logic              err_tag_adr,
    input  logic              req_is_dma,
    input  logic              req_victim,
    input  logic [CODE_W-1:0] cpu_req,
    input  logic [CODE_W-1:0] io_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat_rd,
    output logic [ADDR_W-1:0] err_addr
);
    typedef struct packed {
        stat_t             stat;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_ERR-1:0] err_vec;
    logic               locked;
    logic               capture;
    logic               lost_evt;
    logic [CODE_W-1:0]  cause_sel;
    logic [NUM_W1C-1:0] w1c_cur, w1c_set, w1c_clr, w1c_nxt;
    logic               unused_wr_hi;

    assign err_vec      = {err_nxm, err_tag_ctl, err_tag_adr};
    assign locked       = state_q.stat.nxm | state_q.stat.tag_ctl | state_q.stat.tag_adr;
    assign unused_wr_hi = ^wr_data[STAT_W-1:NUM_W1C];

    errcap_event u_event (
        .err_vec  (err_vec),
        .locked   (locked),
        .capture  (capture),
        .lost_evt (lost_evt)
    );

    errcap_cause_sel u_cause (
        .is_dma   (req_is_dma),
        .cpu_code (cpu_req),
        .io_code  (io_cmd),
        .cause    (cause_sel)
    );

    assign w1c_cur = {state_q.stat.nxm, state_q.stat.tag_ctl,
                      state_q.stat.tag_adr, state_q.stat.lost};
    assign w1c_set = {err_vec & {NUM_ERR{capture}}, lost_evt};
    assign w1c_clr = wr_en ? wr_data[NUM_W1C-1:0] : '0;

    for (genvar i = 0; i < NUM_W1C; i++) begin : g_w1c
        errcap_w1c_bit u_bit (
            .cur (w1c_cur[i]),
            .set (w1c_set[i]),
            .clr (w1c_clr[i]),
            .nxt (w1c_nxt[i])
        );
    end

    always_comb begin
        state_d              = state_q;
        state_d.stat.nxm     = w1c_nxt[3];
        state_d.stat.tag_ctl = w1c_nxt[2];
        state_d.stat.tag_adr = w1c_nxt[1];
        state_d.stat.lost    = w1c_nxt[0];
        if (capture) begin
            state_d.stat.cause  = cause_sel;
            state_d.stat.dma    = req_is_dma;
            state_d.stat.victim = req_victim & err_nxm;
            state_d.addr        = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_rd  = state_q.stat;
    assign err_addr = state_q.addr;

endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
    import errcap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_nxm,
    input logic              err_tag_ctl,
    input logic              err_tag_adr,
    input logic              req_is_dma,
    input logic              req_victim,
    input logic [CODE_W-1:0] cpu_req,
    input logic [CODE_W-1:0] io_cmd,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic [STAT_W-1:0] stat_rd,
    input logic [ADDR_W-1:0] err_addr
);
    logic lk, any;
    assign lk  = |stat_rd[3:1];
    assign any = err_nxm | err_tag_ctl | err_tag_adr;

    // R7
    lost_on_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk && any) |=> stat_rd[0]);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk |=> $stable(err_addr));

    // R6
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk && any) |=> (err_addr == $past(req_addr)));

    // R4
    cause_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk && any && req_is_dma) |=> (stat_rd[8:6] == $past(io_cmd)) && stat_rd[4]);

    // R4
    cause_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk && any && !req_is_dma) |=> (stat_rd[8:6] == $past(cpu_req)) && !stat_rd[4]);

    // R5
    victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk && any && !err_nxm) |=> !stat_rd[5]);

    // R11
    no_lost_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk && !(wr_en && wr_data[0])) |=> (stat_rd[0] == $past(stat_rd[0])));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk && err_nxm) |=> stat_rd[3]);

    // R8
    ro_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lk && any) |=> $stable(stat_rd[8:4]));

    logic unused_chk;
    assign unused_chk = req_victim ^ (^cpu_req) ^ (^wr_data);
endmodule

bind err_capture_reg errcap_chk #(.ADDR_W(ADDR_W)) u_errcap_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_nxm     (err_nxm),
    .err_tag_ctl (err_tag_ctl),
    .err_tag_adr (err_tag_adr),
    .req_is_dma  (req_is_dma),
    .req_victim  (req_victim),
    .cpu_req     (cpu_req),
    .io_cmd      (io_cmd),
    .req_addr    (req_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .stat_rd     (stat_rd),
    .err_addr    (err_addr)
);

// File: tb/tb_err_capture_reg.sv
`timescale 1ns/1ps
module tb_err_capture_reg;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_nxm = 0, err_tag_ctl = 0, err_tag_adr = 0;
    logic          req_is_dma = 0, req_victim = 0;
    logic [2:0]    cpu_req = 0, io_cmd = 0;
    logic [AW-1:0] req_addr = 0;
    logic          wr_en = 0;
    logic [8:0]    wr_data = 0;
    logic [8:0]    stat_rd;
    logic [AW-1:0] err_addr;

    logic [8:0]    m_stat;
    logic [AW-1:0] m_addr;
    int            n_vec = 0, n_bad = 0;
    bit            finished = 0;

    always #2.5 clk = ~clk;

    err_capture_reg #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .err_nxm(err_nxm), .err_tag_ctl(err_tag_ctl),
        .err_tag_adr(err_tag_adr), .req_is_dma(req_is_dma), .req_victim(req_victim),
        .cpu_req(cpu_req), .io_cmd(io_cmd), .req_addr(req_addr), .wr_en(wr_en),
        .wr_data(wr_data), .stat_rd(stat_rd), .err_addr(err_addr)
    );

    // Expected status after one clock, from the requirements.
    function automatic logic [8:0] f_stat(input logic [8:0] s, input logic [2:0] e,
            input logic dma, input logic vic, input logic [2:0] cpu,
            input logic [2:0] io, input logic we, input logic [8:0] wd);
        logic [8:0] n;
        logic [3:0] clr;
        logic       lk;
        n   = s;
        lk  = |s[3:1];
        clr = we ? wd[3:0] : 4'b0;
        n[3:0] = s[3:0] & ~clr;                       // R8
        if (!lk && |e) begin                          // R3
            n[3:1] = n[3:1] | e;                      // R10
            n[8:6] = dma ? io : cpu;                  // R4
            n[5]   = vic & e[2];                      // R5
            n[4]   = dma;
        end
        if (lk && |e) n[0] = 1'b1;                    // R7
        return n;
    endfunction

    function automatic logic [AW-1:0] f_addr(input logic [8:0] s, input logic [2:0] e,
            input logic [AW-1:0] cur, input logic [AW-1:0] a);
        return (!(|s[3:1]) && |e) ? a : cur;          // R6
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (stat_rd !== m_stat || err_addr !== m_addr) begin
            n_bad++;
            $display("FAIL %s: stat=%h addr=%h expected stat=%h addr=%h",
                     tag, stat_rd, err_addr, m_stat, m_addr);
        end
    endtask

    task automatic check_const(input string tag, input logic [8:0] exp);
        n_vec++;
        if (stat_rd !== exp) begin
            n_bad++;
            $display("FAIL %s: stat=%h expected %h", tag, stat_rd, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, sample at the next falling edge.
    task automatic step(input logic [2:0] e, input logic dma, input logic vic,
            input logic [2:0] cpu, input logic [2:0] io, input logic [AW-1:0] a,
            input logic we, input logic [8:0] wd);
        logic [8:0]    ns;
        logic [AW-1:0] na;
        {err_nxm, err_tag_ctl, err_tag_adr} = e;
        req_is_dma = dma; req_victim = vic; cpu_req = cpu; io_cmd = io;
        req_addr = a; wr_en = we; wr_data = wd;
        ns = f_stat(m_stat, e, dma, vic, cpu, io, we, wd);
        na = f_addr(m_stat, e, m_addr, a);
        @(negedge clk);
        m_stat = ns;
        m_addr = na;
    endtask

    task automatic idle();
        step(3'b000, 0, 0, 3'd0, 3'd0, '0, 0, 9'h0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_stat = '0;
        m_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_const("R1 reset status", 9'h000);
        check("R1 reset address");

        // First fault: CPU nonexistent-address, victim write, cpu code 5.
        step(3'b100, 0, 1, 3'd5, 3'd2, 32'hDEAD_0040, 0, 9'h0);
        check_const("R2 field layout", {3'd5, 1'b1, 1'b0, 1'b1, 3'b000});
        check("R3 R4 R5 R6 first capture");

        // Tag control error while locked, different context.
        step(3'b010, 1, 0, 3'd1, 3'd7, 32'h1111_2222, 0, 9'h0);
        check("R7 lost while locked, context frozen");

        // Writes to read-only fields are ignored.
        step(3'b000, 0, 0, 3'd0, 3'd0, '0, 1, 9'h1F0);
        check("R8 read-only fields ignore writes");

        // Clear everything: unlock; cause fields stay.
        step(3'b000, 0, 0, 3'd0, 3'd0, '0, 1, 9'h00F);
        check_const("R8 W1C clear, cause held", {3'd5, 1'b1, 1'b0, 4'b0000});

        // New DMA tag-address fault right after clear.
        step(3'b001, 1, 1, 3'd1, 3'd6, 32'h0BAD_F00D, 0, 9'h0);
        check_const("R9 R4 R5 recapture after unlock", {3'd6, 1'b0, 1'b1, 4'b0010});
        check("R9 fresh address");

        // Locked: clear lost and new error in the same cycle -> lost stays set.
        step(3'b010, 0, 0, 3'd3, 3'd3, 32'h5, 1, 9'h001);
        check("R10 lost set wins over clear");

        // Clear all, then the final clear and a capture test.
        step(3'b000, 0, 0, 3'd0, 3'd0, '0, 1, 9'h00F);
        check("R9 unlock");

        // Two strobes at once, with a write clearing the same bits.
        step(3'b110, 0, 1, 3'd4, 3'd1, 32'hCAFE_0000, 1, 9'h00C);
        check_const("R10 R11 R3 simultaneous set wins, no lost", {3'd4, 1'b1, 1'b0, 4'b1100});
        check("R11 simultaneous capture address");

        // Clearing a bit that was never set keeps the lock.
        step(3'b000, 0, 0, 3'd0, 3'd0, '0, 1, 9'h002);
        check("R9 partial clear keeps lock");
        step(3'b001, 1, 0, 3'd2, 3'd2, 32'h77, 0, 9'h0);
        check("R7 still locked after partial clear");

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] e;
            logic       we;
            e  = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
            we = (($urandom % 3) == 0);
            step(e, 1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
                 $urandom, we, 9'($urandom));
            check("R3 R7 R8 R10 random traffic");
        end

        idle();
        check("R6 idle hold");
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule